// File: doc/BRIEF.md
# IR Run-Length Carrier Transmitter

This block turns a stream of run-length coded bytes into an infrared drive signal. A host pushes bytes into a 16-entry transmit FIFO. Each byte describes one run: either a burst of carrier (a mark) or a stretch of silence (a space). The length of a run is a whole number of 10 us ticks. Runs play back to back with no idle clock between them, on whichever of four IR outputs is currently selected. Only the selected output is ever driven.

The host keeps the FIFO topped up by watching a low-water interrupt. To mark the final byte of a message, it raises an end-of-message flag just before writing that byte. When the FIFO then drains, the message has finished normally and the empty interrupt goes high. If the FIFO drains while the end-of-message flag is clear, the block records an underrun and raises its error interrupt. The underrun flag stays set until the host clears it.

The carrier frequency comes from a 5-bit code, and the output selection from a 2-bit code. The host may change either one only while no run is playing.

Top module: `ir_burst_tx`

## Requirements
- R1: A byte's bit 7 selects the run type: 0 means mark and 1 means space. Bits 6:0 hold a value X, and the run lasts (X+1) ticks of CLK_HZ/100000 clocks each. A transmission starts on the clock after the FIFO becomes non-empty while idle. The next byte loads on the clock where the current run ends, so `busy` stays high for exactly the sum of all run lengths.
- R2: The FIFO holds 16 bytes. A write to a full FIFO is ignored. `fifo_level` reports the number of bytes held.
- R3: `irq_low` is high whenever `fifo_level` is 3 or less. `irq_empty` is high when the FIFO holds nothing and no run is playing.
- R4: `cfg_port` value n routes the carrier to `ir_out[n]`. At most one output bit is ever high. After reset, `ir_out[0]` is selected. All outputs are low while idle and during a space.
- R5: During a mark, the selected output is high for the first round(CLK_HZ*7/1e6) clocks of each carrier period. The period is round(CLK_HZ/f) clocks. The carrier phase restarts at the first clock of every mark byte.
- R6: The carrier code c sets the frequency f as follows:
  - c = 0 to 2 gives f = 58 + c kHz.
  - c = 3 to 29 gives f = c + 27 kHz.
  - c = 30 or 31 gives f = 56.9 kHz.
  - After reset the code is 9, which gives 36 kHz.
- R7: A `cfg_we` pulse while `busy` is high has no effect on the carrier code or on the output selection.
- R8: When `eot_set` has been pulsed before the last byte of a message, the FIFO draining ends the message normally. `underrun` stays low, and the end-of-message flag is consumed, so the next message needs it again.
- R9: When the final run of a message ends with the FIFO empty and no end-of-message flag set, `underrun` and `irq_err` go high. They stay high until `urun_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Run byte: bit 7 = space, bits 6:0 = X |
| eot_set | input | 1 | Pulse to mark that the next byte written ends the message |
| urun_clr | input | 1 | Pulse to clear the underrun flag |
| cfg_we | input | 1 | Load carrier code and output select (idle only) |
| cfg_carrier | input | 5 | Carrier code |
| cfg_port | input | 2 | Output select |
| ir_out | output | 4 | Modulated IR outputs |
| busy | output | 1 | A run is playing |
| fifo_level | output | 5 | Bytes held in the FIFO |
| irq_low | output | 1 | FIFO at or below 3 bytes |
| irq_empty | output | 1 | FIFO drained and idle |
| irq_err | output | 1 | Underrun interrupt |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The embedded assertions check the following on every cycle:
- at most one output is high;
- the configuration stays frozen while a run is playing;
- the FIFO count never exceeds its depth;
- the underrun flag is sticky;
- the underrun flag never rises while an end-of-message flag is pending.

Run lengths, the exact carrier duty, and the frequency for each of the 32 carrier codes can only be shown by the bench. It sweeps every code and every output, and measures busy time and high-clock counts against arithmetic from R1, R5 and R6. The bench also covers the full-FIFO write, the end-of-message handshake against underrun, and a configuration write made during a run.

// File: rtl/ir_burst_tx.sv
module ir_burst_tx #(
  parameter int CLK_HZ   = 24_000_000,
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 3,
  parameter int NOUT     = 4,
  parameter int HIGH_US  = 7,
  parameter int RST_CODE = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eot_set,
  input  logic       urun_clr,
  input  logic       cfg_we,
  input  logic [4:0] cfg_carrier,
  input  logic [1:0] cfg_port,
  output logic [3:0] ir_out,
  output logic       busy,
  output logic [4:0] fifo_level,
  output logic       irq_low,
  output logic       irq_empty,
  output logic       irq_err,
  output logic       underrun
);
  localparam int TICK_DIV  = CLK_HZ / 100_000;
  localparam int HIGH_CLKS = ((CLK_HZ / 1000) * HIGH_US + 500) / 1000;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TICK_DIV);
  localparam int PW = $clog2(CLK_HZ / 29_000 + 1);
  localparam int SW = $clog2(NOUT);

  function automatic int code_hz(input int c);
    if (c <= 2) return 58_000 + c * 1000;
    if (c >= 30) return 56_900;
    return (c + 27) * 1000;
  endfunction

  logic [PW-1:0] per_tab [32];
  for (genvar g = 0; g < 32; g++) begin : g_per
    assign per_tab[g] = PW'((CLK_HZ + code_hz(g) / 2) / code_hz(g));
  end

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] count;
  logic          active, is_space, eot_flag;
  logic [6:0]    run_left;
  logic [TW-1:0] tick_cnt;
  logic [PW-1:0] car_cnt;
  logic [4:0]    car_code;
  logic [SW-1:0] port_sel;

  wire [7:0] head     = mem[rp];
  wire       push     = wr_en && (count != LW'(DEPTH));
  wire       tick_end = (tick_cnt == TW'(TICK_DIV - 1));
  wire       run_end  = active && tick_end && (run_left == 7'd0);
  wire       pop      = (count != '0) && (!active || run_end);
  wire       msg_end  = run_end && (count == '0);
  wire       car_wrap = (car_cnt == per_tab[car_code] - PW'(1));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_space <= 1'b1;
      run_left <= '0;
      tick_cnt <= '0;
      car_cnt  <= '0;
    end else if (pop) begin
      active   <= 1'b1;
      is_space <= head[7];
      run_left <= head[6:0];
      tick_cnt <= '0;
      car_cnt  <= '0;
    end else if (active) begin
      if (run_end) active <= 1'b0;
      tick_cnt <= tick_end ? '0 : tick_cnt + 1'b1;
      if (tick_end && run_left != 7'd0) run_left <= run_left - 1'b1;
      car_cnt <= car_wrap ? '0 : car_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eot_flag <= 1'b0;
      underrun <= 1'b0;
      car_code <= 5'(RST_CODE);
      port_sel <= '0;
    end else begin
      if (eot_set)      eot_flag <= 1'b1;
      else if (msg_end) eot_flag <= 1'b0;
      if (msg_end && !eot_flag) underrun <= 1'b1;
      else if (urun_clr)        underrun <= 1'b0;
      if (cfg_we && !active) begin
        car_code <= cfg_carrier;
        port_sel <= cfg_port;
      end
    end
  end

  assign ir_out     = (active && !is_space && car_cnt < PW'(HIGH_CLKS))
                      ? (NOUT'(1) << port_sel) : '0;
  assign busy       = active;
  assign fifo_level = count;
  assign irq_low    = (count <= LW'(LOW_MARK));
  assign irq_empty  = (count == '0) && !active;
  assign irq_err    = underrun;

  a_r4_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ir_out));

  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(car_code) && $stable(port_sel)));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(underrun) && !$past(urun_clr)) |-> underrun);

  a_r8_eot_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !$past(eot_flag));
endmodule

// File: tb/tb_ir_burst_tx.sv
module tb_ir_burst_tx;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 2_400_000;
  localparam int TICK = CLK_HZ / 100_000;
  localparam int HIGH = ((CLK_HZ / 1000) * 7 + 500) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, eot_set = 1'b0, urun_clr = 1'b0, cfg_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] cfg_carrier = '0;
  logic [1:0] cfg_port = '0;
  logic [3:0] ir_out;
  logic busy, irq_low, irq_empty, irq_err, underrun;
  logic [4:0] fifo_level;

  ir_burst_tx #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .eot_set(eot_set), .urun_clr(urun_clr), .cfg_we(cfg_we),
    .cfg_carrier(cfg_carrier), .cfg_port(cfg_port), .ir_out(ir_out),
    .busy(busy), .fifo_level(fifo_level), .irq_low(irq_low),
    .irq_empty(irq_empty), .irq_err(irq_err), .underrun(underrun));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int busy_cnt = 0;
  int hi_cnt [4] = '{0, 0, 0, 0};
  bit low_bad = 0, err_bad = 0;
  logic [7:0] msg [32];
  int b0;
  int h0 [4];

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      for (int i = 0; i < 4; i++) hi_cnt[i] += int'(ir_out[i]);
      if (irq_low != (fifo_level <= 5'd3)) low_bad = 1;
      if (irq_err != underrun) err_bad = 1;
    end
  end

  function automatic int code_hz(int c);
    if (c <= 2) return 58_000 + c * 1000;
    if (c >= 30) return 56_900;
    return (c + 27) * 1000;
  endfunction

  function automatic int per_of(int c);
    return (CLK_HZ + code_hz(c) / 2) / code_hz(c);
  endfunction

  function automatic int exp_high(int len, int per);
    int r = len % per;
    return (len / per) * HIGH + ((r < HIGH) ? r : HIGH);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic snap();
    b0 = busy_cnt;
    for (int i = 0; i < 4; i++) h0[i] = hi_cnt[i];
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (3) step();
    while (busy && guard < 20000) begin
      step();
      guard++;
    end
    step();
  endtask

  task automatic tx_msg(int n, bit eot);
    snap();
    for (int i = 0; i < n; i++) begin
      if (eot && i == n - 1) begin
        eot_set = 1'b1;
        step();
        eot_set = 1'b0;
      end
      wr_en = 1'b1;
      wr_data = msg[i];
      step();
      wr_en = 1'b0;
    end
    wait_idle();
  endtask

  task automatic cfg(int code, int port);
    cfg_we = 1'b1;
    cfg_carrier = 5'(code);
    cfg_port = 2'(port);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic clr_urun();
    urun_clr = 1'b1;
    step();
    urun_clr = 1'b0;
  endtask

  function automatic int exp_busy(int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += (int'(msg[i][6:0]) + 1) * TICK;
    return s;
  endfunction

  function automatic int exp_hi(int n, int code);
    int s = 0;
    for (int i = 0; i < n; i++)
      if (!msg[i][7]) s += exp_high((int'(msg[i][6:0]) + 1) * TICK, per_of(code));
    return s;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    chk("R4", "reset ir_out", int'(ir_out), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R2", "reset level", int'(fifo_level), 0);
    chk("R3", "reset irq_low", int'(irq_low), 1);
    chk("R3", "reset irq_empty", int'(irq_empty), 1);
    chk("R9", "reset underrun", int'(underrun), 0);

    // R6 reset carrier code 9 and R4 default output 0
    msg[0] = 8'h13;
    tx_msg(1, 1);
    chk("R6", "reset carrier high count", hi_cnt[0] - h0[0], exp_hi(1, 9));
    chk("R4", "reset other outputs", hi_cnt[1] + hi_cnt[2] + hi_cnt[3] - h0[1] - h0[2] - h0[3], 0);
    chk("R1", "single run busy", busy_cnt - b0, exp_busy(1));
    chk("R8", "normal finish no underrun", int'(underrun), 0);
    chk("R3", "empty after drain", int'(irq_empty), 1);

    // R2 fill beyond depth
    snap();
    for (int i = 0; i < 18; i++) begin
      wr_en = 1'b1;
      wr_data = 8'h00;
      step();
    end
    wr_en = 1'b0;
    chk("R2", "level when full", int'(fifo_level), 16);
    chk("R3", "irq_low when full", int'(irq_low), 0);
    chk("R3", "irq_empty when full", int'(irq_empty), 0);
    wait_idle();
    chk("R2", "full write dropped busy", busy_cnt - b0, 17 * TICK);
    chk("R3", "irq_low tracks level", int'(low_bad), 0);
    chk("R9", "underrun without eot", int'(underrun), 1);
    chk("R9", "irq_err with underrun", int'(irq_err), 1);
    repeat (5) step();
    chk("R9", "underrun sticky", int'(underrun), 1);
    clr_urun();
    chk("R9", "underrun cleared", int'(underrun), 0);

    // R1 mixed message, R8 handshake
    msg[0] = 8'h04; msg[1] = 8'h82; msg[2] = 8'h00; msg[3] = 8'h85; msg[4] = 8'h07;
    tx_msg(5, 1);
    chk("R1", "mixed busy", busy_cnt - b0, exp_busy(5));
    chk("R5", "mixed high", hi_cnt[0] - h0[0], exp_hi(5, 9));
    chk("R8", "mixed no underrun", int'(underrun), 0);

    // R8 flag consumed: next message without it underruns
    msg[0] = 8'h01;
    tx_msg(1, 0);
    chk("R8", "eot consumed", int'(underrun), 1);
    clr_urun();

    // R1 duration sweep, spaces silent
    begin
      int xs [7] = '{0, 1, 2, 5, 17, 63, 127};
      for (int k = 0; k < 7; k++) begin
        msg[0] = {k[0], 7'(xs[k])};
        tx_msg(1, 1);
        chk("R1", $sformatf("run X=%0d busy", xs[k]), busy_cnt - b0, (xs[k] + 1) * TICK);
        chk("R4", $sformatf("run X=%0d high", xs[k]), hi_cnt[0] - h0[0], exp_hi(1, 9));
      end
    end

    // R4 port sweep
    for (int p = 0; p < 4; p++) begin
      cfg(9, p);
      msg[0] = 8'h09;
      tx_msg(1, 1);
      for (int q = 0; q < 4; q++)
        chk("R4", $sformatf("port %0d out %0d", p, q), hi_cnt[q] - h0[q],
            (p == q) ? exp_hi(1, 9) : 0);
    end

    // R5/R6 carrier code sweep
    for (int c = 0; c < 32; c++) begin
      cfg(c, 2);
      msg[0] = 8'h13; msg[1] = 8'h8 + 8'h00; msg[1] = 8'h02;
      tx_msg(2, 1);
      chk("R6", $sformatf("code %0d high", c), hi_cnt[2] - h0[2], exp_hi(2, c));
    end

    // R7 config during busy ignored
    cfg(9, 1);
    snap();
    eot_set = 1'b1; step(); eot_set = 1'b0;
    wr_en = 1'b1; wr_data = 8'h27; step(); wr_en = 1'b0;
    repeat (5) step();
    cfg(0, 3);
    wait_idle();
    msg[0] = 8'h13;
    tx_msg(1, 1);
    chk("R7", "port kept", hi_cnt[1] - h0[1], exp_hi(1, 9));
    chk("R7", "ignored port silent", hi_cnt[3] - h0[3], 0);

    chk("R9", "irq_err tracks underrun", int'(err_bad), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule